// File: doc/BRIEF.md
# Hot-Plug Detect Pulse Filter

This block turns an asynchronous hot-plug detect pin into a clean, debounced connection level for the clock domain that samples it. The raw pin first passes through a chain of synchronizing flops. A run counter then measures how long the synchronized value has held. A new level is accepted only when that run is long enough to clear two separate programmable limits. The first is a short glitch limit, counted in clock cycles. The second is a coarse stability limit, counted in units of 1024 clock cycles.

The accepted level comes out as a plain status bit. Every change of that level also raises a one-cycle rise or fall strobe, which an interrupt collector uses. Both limits at zero give the smallest delay: the level follows the pin after synchronization plus one decision register. After reset the level reads 0, which means nothing is connected.

Top module: `hpd_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `hpdLevel`, `hpdRise` and `hpdFall` are 0, whatever the pin does.
- R2: With both limits at 0, a pin change first sampled at clock edge k shows on `hpdLevel` after edge k+2. Two synchronizer edges come first, then one decision edge.
- R3: With `validWidth` at 0, a pin level held for W sampled edges is discarded when W <= `glitchWidth`. When W > `glitchWidth`, it is accepted after edge k+2+`glitchWidth`.
- R4: With `validWidth` = M (M > 0), a level held for W <= M*1024 sampled edges is discarded. When W > M*1024, it is accepted after edge k+2+M*1024.
- R5: The limit in force is the larger of `glitchWidth` and `validWidth`*1024. Both comparisons must pass in the same cycle before the level updates.
- R6: `hpdRise` is high for exactly one cycle: the cycle in which `hpdLevel` has just turned from 0 to 1. It is not high at any other time.
- R7: `hpdFall` is high for exactly one cycle: the cycle in which `hpdLevel` has just turned from 1 to 0. It is not high at any other time.
- R8: An accepted high pulse of W sampled edges, followed by a long enough low, gives a `hpdLevel` high time of exactly W cycles. It gives one rise strobe and one fall strobe.
- R9: Any change of the synchronized pin restarts the run count. A train of short bounces, each no longer than the limit, causes no level change and no strobe, even when its total length exceeds the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| hpdRaw | input | 1 | Asynchronous hot-plug pin |
| glitchWidth | input | 4 | Glitch limit N in cycles; runs of N or fewer cycles are rejected |
| validWidth | input | 12 | Stability limit M; runs of M*1024 or fewer cycles are rejected |
| hpdLevel | output | 1 | Filtered connection level, 0 after reset |
| hpdRise | output | 1 | One-cycle strobe on a 0-to-1 level change |
| hpdFall | output | 1 | One-cycle strobe on a 1-to-0 level change |

## Verification
Two things meet on one edge. The decision that qualifies a new level sets the level register and the matching strobe together. Also, a run-count restart can arrive on the very cycle a run would have qualified. The sweep drives pulses one cycle shorter than the limit, equal to it and one cycle longer, for every glitch value and for several stability multiples. For each pulse, the bench measures the edge of the first strobe and the number of high cycles, and compares both with numbers computed from the limit. A bounce train then places a restart right where the earlier run would have crossed the limit. The bench confirms that no strobe fires and the level does not move.

// File: rtl/hpdf_pkg.sv
package hpdf_pkg;
  // strobes from the level controller to the run-length datapath
  typedef struct packed {
    logic restart;  // synchronized pin differs from last cycle
    logic pending;  // synchronized pin differs from filtered level
  } hpdStrobes_t;
endpackage

// File: rtl/hpd_sync.sv
module hpd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= din;
        end
      end else begin : gRest
        always_ff @(posedge clk) begin
          if (!rstN) chain[g] <= 1'b0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hpd_run_datapath.sv
module hpd_run_datapath
  import hpdf_pkg::*;
#(
  parameter int GLITCH_W   = 4,
  parameter int VALID_W    = 12,
  parameter int SCALE_LOG2 = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  hpdStrobes_t         strb,
  input  logic [GLITCH_W-1:0] glitchWidth,
  input  logic [VALID_W-1:0]  validWidth,
  output logic                qualified
);
  localparam int CNT_W = VALID_W + SCALE_LOG2 + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] runLen;
  logic [CNT_W-1:0] validLimit;
  logic             glitchOk;
  logic             validOk;

  // run length including the current cycle, saturating
  always_comb begin
    if (strb.restart)          runLen = CNT_ONE;
    else if (runCnt == CNT_MAX) runLen = runCnt;
    else                       runLen = runCnt + 1'b1;
  end

  assign validLimit = CNT_W'({validWidth, {SCALE_LOG2{1'b0}}});
  assign glitchOk   = runLen > CNT_W'(glitchWidth);
  assign validOk    = runLen > validLimit;
  assign qualified  = strb.pending && glitchOk && validOk;

  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else       runCnt <= runLen;
  end

  // R9
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> (runCnt == CNT_ONE));

  // R9
  run_counts_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.restart && runCnt != CNT_MAX) |=> (runCnt == $past(runCnt) + 1'b1));

  // R5
  qualify_limits_chk: assert property (@(posedge clk) disable iff (!rstN)
    qualified |-> (runLen > validLimit && runLen > CNT_W'(glitchWidth)));
endmodule

// File: rtl/hpd_level_ctrl.sv
module hpd_level_ctrl
  import hpdf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncHpd,
  input  logic        qualified,
  output hpdStrobes_t strb,
  output logic        hpdLevel,
  output logic        riseEvt,
  output logic        fallEvt
);
  logic prevSync;
  logic levelQ;
  logic pendingSig;

  assign pendingSig   = syncHpd != levelQ;
  assign strb.restart = syncHpd != prevSync;
  assign strb.pending = pendingSig;
  assign hpdLevel     = levelQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSync <= 1'b0;
      levelQ   <= 1'b0;
      riseEvt  <= 1'b0;
      fallEvt  <= 1'b0;
    end else begin
      prevSync <= syncHpd;
      if (qualified) levelQ <= syncHpd;
      riseEvt <= qualified &&  syncHpd;
      fallEvt <= qualified && !syncHpd;
    end
  end

  // R6
  rise_tracks_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    riseEvt == $rose(levelQ));

  // R7
  fall_tracks_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    fallEvt == $fell(levelQ));

  // R6
  no_dual_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(riseEvt && fallEvt));

  // R5
  level_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelQ != $past(levelQ)) |-> (levelQ == $past(syncHpd)));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pendingSig |=> $stable(levelQ));
endmodule

// File: rtl/hpd_filter.sv
module hpd_filter
  import hpdf_pkg::*;
#(
  parameter int GLITCH_W    = 4,
  parameter int VALID_W     = 12,
  parameter int SCALE_LOG2  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hpdRaw,
  input  logic [GLITCH_W-1:0] glitchWidth,
  input  logic [VALID_W-1:0]  validWidth,
  output logic                hpdLevel,
  output logic                hpdRise,
  output logic                hpdFall
);
  logic        syncHpd;
  logic        qualified;
  hpdStrobes_t strb;

  hpd_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (hpdRaw),
    .dout(syncHpd)
  );

  hpd_level_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .syncHpd  (syncHpd),
    .qualified(qualified),
    .strb     (strb),
    .hpdLevel (hpdLevel),
    .riseEvt  (hpdRise),
    .fallEvt  (hpdFall)
  );

  hpd_run_datapath #(
    .GLITCH_W  (GLITCH_W),
    .VALID_W   (VALID_W),
    .SCALE_LOG2(SCALE_LOG2)
  ) uRun (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .glitchWidth(glitchWidth),
    .validWidth (validWidth),
    .qualified  (qualified)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!hpdLevel && !hpdRise && !hpdFall));
endmodule

// File: tb/tb_hpd_filter.sv
module tb_hpd_filter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hpdRaw = 1'b0;
  logic [3:0]  glitchWidth = '0;
  logic [11:0] validWidth = '0;
  logic        hpdLevel, hpdRise, hpdFall;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hpd_filter dut (
    .clk(clk), .rstN(rstN), .hpdRaw(hpdRaw),
    .glitchWidth(glitchWidth), .validWidth(validWidth),
    .hpdLevel(hpdLevel), .hpdRise(hpdRise), .hpdFall(hpdFall)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // drive a high pulse sampled on w edges, then observe
  task automatic runPulse(input int w, input int n, input int m, input string tag);
    int thr = (m * 1024 > n) ? m * 1024 : n;
    bit acc = w > thr;
    int span = w + thr + 12;
    int rises = 0, falls = 0, highs = 0, firstRise = -1;
    @(negedge clk);
    glitchWidth = 4'(n);
    validWidth  = 12'(m);
    hpdRaw = 1'b1;
    for (int i = 1; i <= span; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == w) hpdRaw = 1'b0;
      if (hpdRise) begin rises++; if (firstRise < 0) firstRise = i; end
      if (hpdFall) falls++;
      if (hpdLevel) highs++;
    end
    check(rises == (acc ? 1 : 0), {tag, " rise count"}, rises, acc ? 1 : 0);
    check(falls == (acc ? 1 : 0), {tag, " R7 fall count"}, falls, acc ? 1 : 0);
    check(highs == (acc ? w : 0), {tag, " R8 high time"}, highs, acc ? w : 0);
    if (acc) check(firstRise == thr + 3, {tag, " R6 rise edge"}, firstRise, thr + 3);
  endtask

  initial begin
    // R1: reset holds outputs low while the pin is high
    hpdRaw = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!hpdLevel && !hpdRise && !hpdFall, "R1 in reset", int'(hpdLevel), 0);
    hpdRaw = 1'b0;
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(!hpdLevel && !hpdRise && !hpdFall, "R1 after reset", int'(hpdLevel), 0);
    repeat (4) @(negedge clk);

    // R2: zero limits, single-edge pulse
    runPulse(1, 0, 0, "R2");

    // R3: glitch limit sweep
    for (int n = 0; n < 16; n++)
      for (int w = 1; w <= n + 2; w++)
        runPulse(w, n, 0, "R3");

    // R4 / R5: stability limit at its boundaries
    runPulse(1024, 0, 1, "R4");
    runPulse(1025, 0, 1, "R4");
    runPulse(2048, 3, 2, "R4");
    runPulse(2049, 3, 2, "R4");
    runPulse(1025, 15, 1, "R5");
    runPulse(15, 15, 0, "R5");

    // R9: bounces of 4 edges each against a limit of 5
    begin
      int evts = 0;
      int highs = 0;
      @(negedge clk);
      glitchWidth = 4'd5;
      validWidth  = '0;
      for (int i = 0; i < 30; i++) begin
        hpdRaw = (i < 4) || (i >= 5 && i < 9);
        @(posedge clk);
        @(negedge clk);
        if (hpdRise || hpdFall) evts++;
        if (hpdLevel) highs++;
      end
      check(evts == 0, "R9 bounce strobes", evts, 0);
      check(highs == 0, "R9 bounce level", highs, 0);
    end
    runPulse(6, 5, 0, "R9 clean");

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule